// File: doc/BRIEF.md
# Host Interrupt Request Controller

This block builds the sixteen-line host interrupt request vector that a low-pin-count bus peripheral forwards to the host on its serial interrupt line. Four bus channels and one on-chip serial port are the sources. Each channel owns a word of enable bits, and an output-buffer-full flag gates the channel's requests. A single mode input chooses how a host read of a channel's output data interacts with those enables. Encoding the serial interrupt frame on the wire is not part of this block.

Every enable bit is a two-state machine with the states `EN_DISARMED` and `EN_ARMED`. `SET` is a register write of 1 and moves `EN_DISARMED` to `EN_ARMED`. `DROP` is a register write of 0 and moves `EN_ARMED` to `EN_DISARMED`. `AUTO_CLR` also moves `EN_ARMED` to `EN_DISARMED`; it is a host read pulse on that channel while the mode input is 0, with no write to the channel in the same cycle. `HOLD` covers every other case and leaves the state as it is. All cells enter `EN_DISARMED` at reset. Serial-port enable cells never take `AUTO_CLR`.

In output vector `irq_vec`, bit 0 is the system-management request and bit n is host line n for n from 1 to 15. Line 2 does not exist. A channel enable word is 17 bits wide: bits 0 to 15 follow the same line positions, and bit 16 is a second system-management enable that only channel 3 implements.

Top module: `hirq_ctrl`

## Requirements
- R1: `irq_vec` bit 0 is the system-management line and bit n (1..15) is host line n; bit 2 is always 0, and a serial enable written at bit 2 reads back 0.
- R2: Channel 1 (index 0) implements enable bits 1 and 12 only; a write of all ones reads back 0x01002 and drives only those lines.
- R3: Channels 2 and 4 (indices 1 and 3) implement enable bits 0, 6, 9, 10 and 11 only; a write of all ones reads back 0x00E41.
- R4: Channel 3 (index 2) implements the same bits as R3 plus bit 16, a second system-management enable that drives line 0 independently of bit 0 (all ones reads back 0x10E41).
- R5: The serial port has its own 16-bit enable register (written by `wr_ser_en` from `wr_data[15:0]`), and serial line n requests when `ser_req[n]` and its enable are both 1; serial enables are never cleared by a host read.
- R6: Every source that targets the same line is ORed into that line.
- R7: With `iedir` = 0, a channel's enabled bit requests its line only while that channel's `obf` is 1.
- R8: With `iedir` = 0, a `host_rd` pulse on a channel clears all of that channel's enable bits at the next clock edge, and its requests drop.
- R9: With `iedir` = 1, a channel's enabled bit requests its line whatever the state of `obf`, and `host_rd` leaves the enable bits unchanged.
- R10: A register write to a channel in the same cycle as its host read loads the written value, which overrides the auto-clear.
- R11: After reset every enable bit is 0 and `irq_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iedir | input | 1 | Mode: 0 = requests gated by buffer-full and auto-cleared on host read, 1 = enable bits alone |
| wr_chan_en | input | 4 | Per-channel write strobe for the channel enable word |
| wr_ser_en | input | 1 | Write strobe for the serial enable register |
| wr_data | input | 17 | Write data for the enable registers |
| obf | input | 4 | Per-channel output-buffer-full flag |
| host_rd | input | 4 | Per-channel pulse for a host read of the output data or the final two-way byte |
| ser_req | input | 16 | Serial-port request levels, one per line |
| irq_vec | output | 16 | Host interrupt request vector |
| chan_en_o | output | 68 | Enable words, channel c at bits [17c+16:17c] |
| ser_en_o | output | 16 | Serial enable register |

## Verification
Two functions can hit the same enable cell in one cycle: a register write to a channel and the host read that auto-clears it. The bench lines up both in one cycle with `iedir` = 0, once writing a 1 and once writing a 0 to the same bit. It then reads the enable word back and checks that the written value survived. A second case raises a host read together with a buffer-full drop while `iedir` = 1, and the request on the line must stay asserted.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
    localparam int NCH      = 4;
    localparam int NLINE    = 16;
    localparam int ENW      = NLINE + 1;
    localparam int SMIB_BIT = NLINE;
    localparam int LINE_SMI = 0;
    localparam int LINE_GAP = 2;

    typedef enum logic {EN_DISARMED, EN_ARMED} en_state_t;

    function automatic logic [ENW-1:0] chan_mask(input int c);
        logic [ENW-1:0] m;
        m = '0;
        if (c == 0) begin
            m[1]  = 1'b1;
            m[12] = 1'b1;
        end else begin
            m[LINE_SMI] = 1'b1;
            m[6]  = 1'b1;
            m[9]  = 1'b1;
            m[10] = 1'b1;
            m[11] = 1'b1;
            if (c == 2) m[SMIB_BIT] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [NLINE-1:0] ser_mask();
        logic [NLINE-1:0] m;
        m = '1;
        m[LINE_GAP] = 1'b0;
        return m;
    endfunction
endpackage

// File: rtl/hirq_en_cell.sv
module hirq_en_cell
    import hirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_val,
    input  logic auto_clr,
    output logic en_o
);
    en_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EN_DISARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_DISARMED: if (wr && wr_val) state_d = EN_ARMED;
            EN_ARMED: begin
                if (wr)            state_d = wr_val ? EN_ARMED : EN_DISARMED;
                else if (auto_clr) state_d = EN_DISARMED;
            end
            default: state_d = EN_DISARMED;
        endcase
    end

    always_comb en_o = (state_q == EN_ARMED);

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (en_o == $past(wr_val)));                        // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !auto_clr) |=> $stable(en_o));                  // R9
    AST_RESET_OFF: assert property (@(posedge clk)
        !rst_n |=> !en_o);                                      // R11
endmodule

// File: rtl/hirq_line_merge.sv
module hirq_line_merge
    import hirq_pkg::*;
(
    input  logic [NCH*ENW-1:0] chan_en,
    input  logic [NCH-1:0]     chan_act,
    input  logic [NLINE-1:0]   ser_en,
    input  logic [NLINE-1:0]   ser_req,
    output logic [NLINE-1:0]   irq
);
    always_comb begin
        irq = ser_en & ser_req;
        for (int c = 0; c < NCH; c++) begin
            if (chan_act[c]) begin
                irq = irq | chan_en[c*ENW +: NLINE];
                irq[LINE_SMI] = irq[LINE_SMI] | chan_en[c*ENW + SMIB_BIT];
            end
        end
        irq[LINE_GAP] = 1'b0;
    end
endmodule

// File: rtl/hirq_ctrl.sv
module hirq_ctrl
    import hirq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iedir,
    input  logic [NCH-1:0]       wr_chan_en,
    input  logic                 wr_ser_en,
    input  logic [ENW-1:0]       wr_data,
    input  logic [NCH-1:0]       obf,
    input  logic [NCH-1:0]       host_rd,
    input  logic [NLINE-1:0]     ser_req,
    output logic [NLINE-1:0]     irq_vec,
    output logic [NCH*ENW-1:0]   chan_en_o,
    output logic [NLINE-1:0]     ser_en_o
);
    logic [NCH-1:0]   auto_clr;
    logic [NCH-1:0]   chan_act;

    always_comb begin
        auto_clr = host_rd & {NCH{~iedir}};
        chan_act = obf | {NCH{iedir}};
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam logic [ENW-1:0] MASK = chan_mask(c);
        for (genvar b = 0; b < ENW; b++) begin : g_bit
            if (MASK[b]) begin : g_cell
                hirq_en_cell u_cell (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .wr       (wr_chan_en[c]),
                    .wr_val   (wr_data[b]),
                    .auto_clr (auto_clr[c]),
                    .en_o     (chan_en_o[c*ENW + b])
                );
            end else begin : g_tie
                assign chan_en_o[c*ENW + b] = 1'b0;
            end
        end

        AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (!iedir && host_rd[c] && !wr_chan_en[c]) |=> (chan_en_o[c*ENW +: ENW] == '0)); // R8
        AST_MODE1_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (iedir && !wr_chan_en[c]) |=> $stable(chan_en_o[c*ENW +: ENW]));            // R9
    end

    localparam logic [NLINE-1:0] SMASK = ser_mask();
    for (genvar b = 0; b < NLINE; b++) begin : g_ser
        if (SMASK[b]) begin : g_cell
            hirq_en_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr       (wr_ser_en),
                .wr_val   (wr_data[b]),
                .auto_clr (1'b0),
                .en_o     (ser_en_o[b])
            );
        end else begin : g_tie
            assign ser_en_o[b] = 1'b0;
        end
    end

    hirq_line_merge u_merge (
        .chan_en  (chan_en_o),
        .chan_act (chan_act),
        .ser_en   (ser_en_o),
        .ser_req  (ser_req),
        .irq      (irq_vec)
    );

    AST_NO_LINE2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_vec[LINE_GAP]);                                                           // R1
    AST_OBF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!iedir && obf == '0 && (ser_en_o & ser_req) == '0) |-> (irq_vec == '0));     // R7
    AST_SER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ser_en |=> $stable(ser_en_o));                                             // R5
endmodule

// File: tb/hirq_ctrl_tb.sv
`timescale 1ns/1ps
module hirq_ctrl_tb;
    import hirq_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iedir = 1'b0;
    logic [NCH-1:0] wr_chan_en = '0;
    logic wr_ser_en = 1'b0;
    logic [ENW-1:0] wr_data = '0;
    logic [NCH-1:0] obf = '0;
    logic [NCH-1:0] host_rd = '0;
    logic [NLINE-1:0] ser_req = '0;
    logic [NLINE-1:0] irq_vec;
    logic [NCH*ENW-1:0] chan_en_o;
    logic [NLINE-1:0] ser_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hirq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .iedir(iedir), .wr_chan_en(wr_chan_en),
        .wr_ser_en(wr_ser_en), .wr_data(wr_data), .obf(obf), .host_rd(host_rd),
        .ser_req(ser_req), .irq_vec(irq_vec), .chan_en_o(chan_en_o), .ser_en_o(ser_en_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [ENW-1:0] en_of(input int c);
        return chan_en_o[c*ENW +: ENW];
    endfunction

    task automatic wr_chan(input int c, input logic [ENW-1:0] d);
        @(negedge clk);
        wr_chan_en[c] = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_chan_en = '0;
    endtask

    task automatic wr_ser(input logic [NLINE-1:0] d);
        @(negedge clk);
        wr_ser_en = 1'b1;
        wr_data = {1'b0, d};
        @(negedge clk);
        wr_ser_en = 1'b0;
    endtask

    task automatic clear_all();
        for (int c = 0; c < NCH; c++) wr_chan(c, '0);
        wr_ser('0);
        obf = '0;
        ser_req = '0;
    endtask

    task automatic t_reset();
        #1;
        chk("R11 enables", {15'd0, chan_en_o[16:0]} | chan_en_o[67:17], 32'd0);
        chk("R11 irq", irq_vec, 32'd0);
    endtask

    task automatic t_layout();
        iedir = 1'b1;
        wr_chan(0, '1);
        chk("R2 ch1 enables", en_of(0), 32'h01002);
        #1 chk("R2 ch1 irq", irq_vec, 32'h1002);
        wr_chan(0, '0);
        wr_chan(1, '1);
        chk("R3 ch2 enables", en_of(1), 32'h00E41);
        wr_chan(3, '1);
        chk("R3 ch4 enables", en_of(3), 32'h00E41);
        wr_chan(2, '1);
        chk("R4 ch3 enables", en_of(2), 32'h10E41);
        clear_all();
        wr_chan(2, 17'h10000);
        #1 chk("R4 ch3 second SMI drives line 0", irq_vec, 32'h0001);
        clear_all();
    endtask

    task automatic t_serial();
        iedir = 1'b0;
        wr_ser('1);
        chk("R1 serial bit2 absent", ser_en_o, 32'hFFFB);
        ser_req = 16'h0004;
        #1 chk("R1 line 2 never requests", irq_vec, 32'h0);
        ser_req = 16'h8008;
        #1 chk("R5 serial lines 3 and 15", irq_vec, 32'h8008);
        @(negedge clk);
        host_rd = '1;
        @(negedge clk);
        host_rd = '0;
        chk("R5 serial not auto-cleared", ser_en_o, 32'hFFFB);
        clear_all();
    endtask

    task automatic t_mode0();
        iedir = 1'b0;
        wr_chan(0, 17'h01002);
        #1 chk("R7 no obf no request", irq_vec, 32'h0);
        obf[0] = 1'b1;
        #1 chk("R7 obf gates request", irq_vec, 32'h1002);
        @(negedge clk);
        host_rd[0] = 1'b1;
        @(negedge clk);
        host_rd[0] = 1'b0;
        obf[0] = 1'b0;
        chk("R8 auto-clear enables", en_of(0), 32'h0);
        obf[0] = 1'b1;
        #1 chk("R8 request dropped", irq_vec, 32'h0);
        clear_all();
    endtask

    task automatic t_mode1();
        iedir = 1'b1;
        wr_chan(1, 17'h00040);
        #1 chk("R9 request without obf", irq_vec, 32'h0040);
        obf[1] = 1'b1;
        @(negedge clk);
        host_rd[1] = 1'b1;
        obf[1] = 1'b0;
        @(negedge clk);
        host_rd[1] = 1'b0;
        chk("R9 enable kept after read", en_of(1), 32'h00040);
        #1 chk("R9 request kept after obf clear", irq_vec, 32'h0040);
        clear_all();
    endtask

    task automatic t_collide();
        iedir = 1'b0;
        obf[3] = 1'b1;
        wr_chan(3, 17'h00200);
        @(negedge clk);
        host_rd[3] = 1'b1;
        wr_chan_en[3] = 1'b1;
        wr_data = 17'h00200;
        @(negedge clk);
        host_rd[3] = 1'b0;
        wr_chan_en = '0;
        chk("R10 write 1 beats auto-clear", en_of(3), 32'h00200);
        #1 chk("R10 request stays", irq_vec, 32'h0200);
        @(negedge clk);
        host_rd[3] = 1'b1;
        wr_chan_en[3] = 1'b1;
        wr_data = 17'h00000;
        @(negedge clk);
        host_rd[3] = 1'b0;
        wr_chan_en = '0;
        chk("R10 write 0 with read", en_of(3), 32'h0);
        clear_all();
    endtask

    task automatic t_or();
        iedir = 1'b1;
        wr_chan(3, 17'h00200);
        wr_chan(1, 17'h00001);
        wr_chan(2, 17'h10000);
        wr_ser(16'h0200);
        ser_req = 16'h0200;
        #1 chk("R6 merged lines", irq_vec, 32'h0201);
        wr_chan(3, '0);
        wr_chan(1, '0);
        #1 chk("R6 serial and ch3 remain", irq_vec, 32'h0201);
        wr_chan(2, '0);
        ser_req = '0;
        #1 chk("R6 all sources off", irq_vec, 32'h0);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_serial();
        t_mode0();
        t_mode1();
        t_collide();
        t_or();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule